// File: doc/BRIEF.md
# Device Table Entry Checker

This block judges one device table entry after it has been fetched from memory. An entry holds 256 bits, split into four 64-bit words, and belongs to one 16-bit requester ID. Each entry sits at the table base plus the requester ID times 32 bytes, and the block returns that byte address with its verdict. From the entry, a fetch-error flag, a flag that says whether host translation is supported, and a flag that says whether remapping is enabled, the block decides what happens to the device's DMA requests. They can pass through untranslated, go through translation, or be isolated. When the device is isolated, the block also asks for all of its existing mappings to be dropped.

The block also checks the entry itself. It looks for reserved bits set in any of the four words, and for a page-table root pointer when the hardware cannot translate. It reports a result code, the mode, domain and permission fields, and a one-cycle illegal-entry event.

Field layout:
- Word 0: bit 0 is the valid flag V, bit 1 is the translation-valid flag TV, bits [11:9] are the mode, bits [51:12] are the root pointer, bit 61 is read permission and bit 62 is write permission.
- Word 1: bits [15:0] are the domain ID.

Top module: `dte_checker`

## Requirements
- R1: Every cycle with `in_valid` high produces, exactly one cycle later, a one-cycle pulse on `out_valid`. `out_valid`, `illegal_evt` and `drop_maps` are low after reset and low in any cycle not following an accepted entry.
- R2: `entry_addr` equals `tbl_base + req_id * 32`, captured with the entry.
- R3: An entry with any reserved bit set is illegal. The reserved bits are word 0 bits [8:2] and bit 63, word 1 bits [63:48], word 2 bits [63:56] and word 3 bits [63:32]. An illegal entry gives result code 4, pulses `illegal_evt`, and gives action isolate (code 2) with `drop_maps`.
- R4: A fetch error (`rd_err`) takes priority over every other case. It gives result code 1, action isolate with `drop_maps`, and no `illegal_evt`.
- R5: A nonzero root pointer (word 0 bits [51:12]) makes the entry illegal, as in R3, when `xlate_sup` is low. The same pointer is accepted when `xlate_sup` is high.
- R6: A legal entry with V=0 gives result code 2 and action passthrough (code 0), with no `drop_maps`.
- R7: A legal entry with V=1 and TV=0 gives result code 3 and action isolate with `drop_maps`.
- R8: A legal entry with V=1 and TV=1 gives result code 0. Its action is passthrough when the mode is 0 and translate (code 1) for any nonzero mode, and `drop_maps` stays low.
- R9: When `remap_en` is low, the action is passthrough and `drop_maps` stays low in every case. The result code and `illegal_evt` are unaffected.
- R10: `mode_out` is word 0 bits [11:9]. `domain_out` is word 1 bits [15:0]. `perm_out` is {word 0 bit 62, word 0 bit 61}, that is {write, read}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Entry and flags present this cycle |
| req_id | input | 16 | Requester ID of the entry |
| tbl_base | input | 64 | Byte base address of the device table |
| entry_bits | input | 256 | Entry; word n occupies bits [64n+63:64n] |
| rd_err | input | 1 | Fetching the entry failed |
| xlate_sup | input | 1 | Host translation is supported |
| remap_en | input | 1 | DMA remapping is enabled |
| out_valid | output | 1 | Verdict valid pulse |
| result | output | 3 | 0 ok, 1 fetch error, 2 V clear, 3 TV clear, 4 illegal |
| action | output | 2 | 0 passthrough, 1 translate, 2 isolate |
| drop_maps | output | 1 | Drop all existing mappings of the device |
| illegal_evt | output | 1 | Illegal-entry event strobe |
| mode_out | output | 3 | Mode field |
| domain_out | output | 16 | Domain ID |
| perm_out | output | 2 | {write, read} permission |
| entry_addr | output | 64 | Byte address of the entry |

## Verification
The bench sets every one of the 256 entry bits in turn on top of a legal translating entry. A design with a misplaced or missing reserved mask would let an illegal entry through, or would flag the mode, root, permission or domain fields as illegal.

A second sweep covers every combination of fetch error, translation support, remap enable, V, TV and all eight mode values, with a nonzero root pointer. This sweep targets wrong priority, such as a fetch error being reported as illegal, and a root check that ignores `xlate_sup`. It also catches a TV=0 entry that is passed through instead of isolated, a mode 0 entry that is translated, and an action that escapes the remap-disabled override.

Address checks use high requester IDs, which expose a shift by the wrong amount or a truncated sum.

// File: rtl/dte_pkg.sv
package dte_pkg;

    localparam int WORD_W      = 64;
    localparam int NUM_WORDS   = 4;
    localparam int ENTRY_W     = WORD_W * NUM_WORDS;
    localparam int MODE_W      = 3;
    localparam int ROOT_W      = 40;
    localparam int DOM_W       = 16;
    localparam int PERM_W      = 2;

    localparam int BIT_V       = 0;
    localparam int BIT_TV      = 1;
    localparam int MODE_LSB    = 9;
    localparam int ROOT_LSB    = 12;
    localparam int PERM_LSB    = 61;

    typedef enum logic [2:0] {
        RES_OK        = 3'd0,
        RES_FETCH_ERR = 3'd1,
        RES_NOT_VALID = 3'd2,
        RES_NO_XLATE  = 3'd3,
        RES_ILLEGAL   = 3'd4
    } dte_result_e;

    typedef enum logic [1:0] {
        ACT_PASS    = 2'd0,
        ACT_XLATE   = 2'd1,
        ACT_ISOLATE = 2'd2
    } dte_action_e;

    typedef struct packed {
        logic              v;
        logic              tv;
        logic [MODE_W-1:0] mode;
        logic [ROOT_W-1:0] root;
        logic [PERM_W-1:0] perm;
        logic [DOM_W-1:0]  domain;
    } dte_fields_t;

    typedef struct packed {
        dte_result_e result;
        dte_action_e action;
        logic        drop;
        logic        illegal;
    } dte_verdict_t;

    function automatic logic [WORD_W-1:0] rsvd_mask(input int w);
        case (w)
            0:       rsvd_mask = 64'h8000_0000_0000_01FC;
            1:       rsvd_mask = 64'hFFFF_0000_0000_0000;
            2:       rsvd_mask = 64'hFF00_0000_0000_0000;
            default: rsvd_mask = 64'hFFFF_FFFF_0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/dte_field_extract.sv
module dte_field_extract
    import dte_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    output dte_fields_t        fields
);
    logic [WORD_W-1:0] w0, w1;

    assign w0 = entry[0 +: WORD_W];
    assign w1 = entry[WORD_W +: WORD_W];

    always_comb begin
        fields.v      = w0[BIT_V];
        fields.tv     = w0[BIT_TV];
        fields.mode   = w0[MODE_LSB +: MODE_W];
        fields.root   = w0[ROOT_LSB +: ROOT_W];
        fields.perm   = w0[PERM_LSB +: PERM_W];
        fields.domain = w1[0 +: DOM_W];
    end
endmodule

// File: rtl/dte_rule_check.sv
module dte_rule_check
    import dte_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic [ROOT_W-1:0]  root,
    input  logic               xlate_sup,
    output logic               illegal
);
    logic [NUM_WORDS-1:0] word_bad;
    logic                 root_bad;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word_bad[w] = |(entry[w*WORD_W +: WORD_W] & rsvd_mask(w));
    end

    assign root_bad = !xlate_sup && (root != '0);
    assign illegal  = (|word_bad) || root_bad;
endmodule

// File: rtl/dte_classify.sv
module dte_classify
    import dte_pkg::*;
(
    input  logic              rd_err,
    input  logic              illegal,
    input  logic              v,
    input  logic              tv,
    input  logic [MODE_W-1:0] mode,
    input  logic              remap_en,
    output dte_verdict_t      verdict
);
    dte_result_e res;
    dte_action_e act;
    logic        drop;

    always_comb begin
        drop = 1'b0;
        if (rd_err) begin
            res  = RES_FETCH_ERR;
            act  = ACT_ISOLATE;
            drop = 1'b1;
        end else if (illegal) begin
            res  = RES_ILLEGAL;
            act  = ACT_ISOLATE;
            drop = 1'b1;
        end else if (!v) begin
            res  = RES_NOT_VALID;
            act  = ACT_PASS;
        end else if (!tv) begin
            res  = RES_NO_XLATE;
            act  = ACT_ISOLATE;
            drop = 1'b1;
        end else begin
            res  = RES_OK;
            act  = (mode == '0) ? ACT_PASS : ACT_XLATE;
        end

        verdict.result  = res;
        verdict.illegal = illegal && !rd_err;
        verdict.action  = remap_en ? act : ACT_PASS;
        verdict.drop    = remap_en && drop;
    end
endmodule

// File: rtl/dte_checker.sv
module dte_checker
    import dte_pkg::*;
#(
    parameter int ID_W      = 16,
    parameter int ADDR_W    = 64,
    parameter int ENTRY_LG2 = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [ID_W-1:0]     req_id,
    input  logic [ADDR_W-1:0]   tbl_base,
    input  logic [255:0]        entry_bits,
    input  logic                rd_err,
    input  logic                xlate_sup,
    input  logic                remap_en,
    output logic                out_valid,
    output logic [2:0]          result,
    output logic [1:0]          action,
    output logic                drop_maps,
    output logic                illegal_evt,
    output logic [2:0]          mode_out,
    output logic [15:0]         domain_out,
    output logic [1:0]          perm_out,
    output logic [ADDR_W-1:0]   entry_addr
);
    localparam int PAD_W = ADDR_W - ID_W - ENTRY_LG2;

    dte_fields_t  fields;
    logic         illegal;
    dte_verdict_t verdict;
    logic [ADDR_W-1:0] offset;

    dte_field_extract u_extract (
        .entry  (entry_bits),
        .fields (fields)
    );

    dte_rule_check u_rules (
        .entry     (entry_bits),
        .root      (fields.root),
        .xlate_sup (xlate_sup),
        .illegal   (illegal)
    );

    dte_classify u_class (
        .rd_err   (rd_err),
        .illegal  (illegal),
        .v        (fields.v),
        .tv       (fields.tv),
        .mode     (fields.mode),
        .remap_en (remap_en),
        .verdict  (verdict)
    );

    assign offset = {{PAD_W{1'b0}}, req_id, {ENTRY_LG2{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            illegal_evt <= 1'b0;
            drop_maps   <= 1'b0;
            result      <= '0;
            action      <= '0;
            mode_out    <= '0;
            domain_out  <= '0;
            perm_out    <= '0;
            entry_addr  <= '0;
        end else begin
            out_valid   <= in_valid;
            illegal_evt <= in_valid && verdict.illegal;
            drop_maps   <= in_valid && verdict.drop;
            if (in_valid) begin
                result     <= verdict.result;
                action     <= verdict.action;
                mode_out   <= fields.mode;
                domain_out <= fields.domain;
                perm_out   <= fields.perm;
                entry_addr <= tbl_base + offset;
            end
        end
    end

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !illegal_evt && !drop_maps); // R1
    AST_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        illegal_evt |-> out_valid && result == 3'd4); // R3
    AST_FETCH_ERR: assert property (@(posedge clk) disable iff (rst)
        in_valid && rd_err |=> result == 3'd1 && !illegal_evt); // R4
    AST_ISOLATE_DROP: assert property (@(posedge clk) disable iff (rst)
        out_valid && action == 2'd2 |-> drop_maps); // R7
    AST_REMAP_OFF: assert property (@(posedge clk) disable iff (rst)
        in_valid && !remap_en |=> action == 2'd0 && !drop_maps); // R9
endmodule

// File: tb/dte_checker_test.sv
module dte_checker_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [63:0] M0 = 64'h8000_0000_0000_01FC;
    localparam logic [63:0] M1 = 64'hFFFF_0000_0000_0000;
    localparam logic [63:0] M2 = 64'hFF00_0000_0000_0000;
    localparam logic [63:0] M3 = 64'hFFFF_FFFF_0000_0000;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [15:0]  req_id;
    logic [63:0]  tbl_base;
    logic [255:0] entry_bits;
    logic         rd_err, xlate_sup, remap_en;
    logic         out_valid, drop_maps, illegal_evt;
    logic [2:0]   result, mode_out;
    logic [1:0]   action, perm_out;
    logic [15:0]  domain_out;
    logic [63:0]  entry_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dte_checker uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .req_id(req_id),
        .tbl_base(tbl_base), .entry_bits(entry_bits), .rd_err(rd_err),
        .xlate_sup(xlate_sup), .remap_en(remap_en), .out_valid(out_valid),
        .result(result), .action(action), .drop_maps(drop_maps),
        .illegal_evt(illegal_evt), .mode_out(mode_out),
        .domain_out(domain_out), .perm_out(perm_out), .entry_addr(entry_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [255:0] e, input logic re, input logic xs,
                         input logic rm, input logic [15:0] id, input logic [63:0] base);
        logic [63:0] w0, w1, w2, w3;
        logic ill, v, tv;
        logic [2:0] eres;
        logic [1:0] eact;
        logic edrop;
        w0 = e[63:0]; w1 = e[127:64]; w2 = e[191:128]; w3 = e[255:192];
        ill = ((w0 & M0) != 0) || ((w1 & M1) != 0) || ((w2 & M2) != 0) ||
              ((w3 & M3) != 0) || (!xs && w0[51:12] != 0);
        v = w0[0]; tv = w0[1];
        edrop = 1'b0;
        if (re)        begin eres = 3'd1; eact = 2'd2; edrop = 1'b1; end
        else if (ill)  begin eres = 3'd4; eact = 2'd2; edrop = 1'b1; end
        else if (!v)   begin eres = 3'd2; eact = 2'd0; end
        else if (!tv)  begin eres = 3'd3; eact = 2'd2; edrop = 1'b1; end
        else           begin eres = 3'd0; eact = (w0[11:9] == 0) ? 2'd0 : 2'd1; end
        if (!rm) begin eact = 2'd0; edrop = 1'b0; end

        @(negedge clk);
        in_valid = 1'b1; entry_bits = e; rd_err = re; xlate_sup = xs;
        remap_en = rm; req_id = id; tbl_base = base;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 out_valid", {63'd0, out_valid}, 64'd1);
        chk(re ? "R4 result" : (ill ? "R3/R5 result" : "R6/R7/R8 result"), {61'd0, result}, {61'd0, eres});
        chk(rm ? "R8 action" : "R9 action", {62'd0, action}, {62'd0, eact});
        chk("R7/R9 drop_maps", {63'd0, drop_maps}, {63'd0, edrop});
        chk("R3 illegal_evt", {63'd0, illegal_evt}, {63'd0, ill && !re});
        chk("R10 mode", {61'd0, mode_out}, {61'd0, w0[11:9]});
        chk("R10 domain", {48'd0, domain_out}, {48'd0, w1[15:0]});
        chk("R10 perm", {62'd0, perm_out}, {62'd0, w0[62], w0[61]});
        chk("R2 entry_addr", entry_addr, base + 64'(id) * 64'd32);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [255:0] base_e;
        logic [63:0] w0;
        rst = 1'b1; in_valid = 1'b0; req_id = '0; tbl_base = '0; entry_bits = '0;
        rd_err = 1'b0; xlate_sup = 1'b1; remap_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1 reset illegal_evt", {63'd0, illegal_evt}, 64'd0);
        chk("R1 reset drop_maps", {63'd0, drop_maps}, 64'd0);

        w0 = 64'd3 | (64'd3 << 9) | (64'h12345 << 12) | (64'd3 << 61);
        base_e = {64'd0, 64'd0, 64'h0000_0000_0000_BEEF, w0};

        // R3: single-bit sweep over the whole entry
        for (int b = 0; b < 256; b++) begin
            logic [255:0] e;
            e = base_e ^ (256'd1 << b);
            apply(e, 1'b0, 1'b1, 1'b1, 16'(b * 257), 64'h0000_1000_0000_0000);
        end

        // R4-R9: flag and mode combinations
        for (int c = 0; c < 32; c++) begin
            for (int m = 0; m < 8; m++) begin
                logic [255:0] e;
                logic [63:0] x;
                x = (w0 & ~64'h0E03) | 64'(c[3]) | (64'(c[4]) << 1) | (64'(m) << 9);
                e = {64'd0, 64'd0, 64'h0000_0000_0000_5A5A, x};
                apply(e, c[0], c[1], c[2], 16'hFFFF - 16'(c * 8 + m), 64'hFFFF_FFFF_FFF0_0000);
            end
        end

        // R5: zero root with translation unsupported stays legal
        apply({128'd0, 64'h0000_0000_0000_0042, 64'h0000_0000_0000_0603}, 1'b0, 1'b0, 1'b1, 16'h8001, 64'd64);

        // R1: no pulse without a new entry
        @(negedge clk);
        chk("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1 idle illegal_evt", {63'd0, illegal_evt}, 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule